// File: doc/BRIEF.md
# Secured Flash Programming Access Controller

This block sits between an external serial programming command port and a byte-wide program memory of 32K locations. It carries out four commands: read one byte, write one byte, erase one page and erase the whole memory. An option byte in the top memory location holds a security bit, and that bit gates every command. The controller decodes the 16-bit command address. It maps the high alias of the option byte onto its physical location, returns read data and refuses any write or erase that is forbidden. It reports progress through a busy level, a one-cycle done pulse and an error flag that marks a refused command.

The option byte is loaded into a shadow register after every reset by reading the memory itself. From then on the shadow follows every write and erase that touches the option byte. An erased option byte (0xFF) counts as unprogrammed. It may be written exactly once, and it becomes writable again only after the last page or the whole memory has been erased. The memory is external to the block. It is reached through a port with a one-cycle synchronous read and a single-cycle write. An erase is carried out as a walk of 0xFF writes over the affected range.

Top module: `flash_sec_ctrl`

## Requirements
- R1: While reset is low and during the two cycles after it, busy is high and done and err are low. In those cycles the option byte is read from location 0x7FFF into the shadow register, after which busy falls.
- R2: A command is taken when cmd_valid is high and busy is low. Busy then stays high for at least one cycle. Done is a single-cycle pulse, and err is high only together with done.
- R3: With security off, a read of an address below 0x8000 returns the stored byte. Never-written or erased bytes return 0xFF.
- R4: A read of 0xFFFF or 0x7FFF returns the current option byte whether security is on or off.
- R5: With security on, a read of any other address returns 0xFF, without error.
- R6: With security on, byte writes (including to the option byte) and page erases are refused with err, and memory is left unchanged.
- R7: A mass erase is accepted whatever the security state. It sets all locations 0x0000 to 0x7FFF to 0xFF and makes the option byte unprogrammed again.
- R8: A page erase sets every byte of the PAGE_BYTES-aligned page containing the address to 0xFF and leaves all other pages untouched.
- R9: The option byte can be written only while it is unprogrammed. A second write is refused with err until the last page is erased or a mass erase runs.
- R10: Security is on when the option byte is programmed and its bit 3 is 1. An unprogrammed option byte (0xFF after erase) leaves security off.
- R11: Addresses 0x8000 to 0xFFFE read as 0xFF without error and are refused with err for writes and page erases.
- R12: cmd_op encodes 00 as read, 01 as write, 10 as page erase and 11 as mass erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | Command code (R12) |
| cmd_addr | input | 16 | Command byte address |
| cmd_wdata | input | 8 | Data for a byte write |
| busy | output | 1 | Controller is occupied |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused, valid with done |
| rdata | output | 8 | Result of the last read command |
| mem_addr | output | 15 | Memory location |
| mem_re | output | 1 | Memory read strobe, data next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The embedded assertions check the following on every cycle:
- the handshake shape (done follows busy, is one cycle wide and carries err);
- that no byte write reaches memory while security is on;
- that the option location is written only while it is unprogrammed;
- that an erase walk drives only 0xFF;
- that the memory port never reads and writes at once.

Only the bench's scenarios can show:
- what data comes back: masking, alias and out-of-range values;
- that a page erase stops at its page boundary;
- that a mass erase really clears a secured part and turns security off;
- that the shadow is reloaded from memory after a fresh reset.

// File: rtl/flashsec_pkg.sv
// Shared types for the secured flash access controller.
// Assumes: a two-bit command code and a small sequencing state machine.
package flashsec_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_PERASE = 2'b10,
        OP_MERASE = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_BOOTWAIT,
        ST_IDLE,
        ST_CHECK,
        ST_RDWAIT,
        ST_ERASE,
        ST_DONE
    } st_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/fsa_addr_decode.sv
// Address classifier for the command port.
// Splits a command address into a physical location and range flags, and
// derives the page boundaries used by a page erase.
// Assumes: CMD_AW > MEM_AW, and PAGE_AW < MEM_AW.
module fsa_addr_decode #(
    parameter int CMD_AW  = 16,
    parameter int MEM_AW  = 15,
    parameter int PAGE_AW = 7
) (
    input  logic [CMD_AW-1:0] addr,
    output logic              in_range,
    output logic              is_alias,
    output logic              is_optp,
    output logic [MEM_AW-1:0] loc,
    output logic [MEM_AW-1:0] pg_first,
    output logic [MEM_AW-1:0] pg_last,
    output logic              in_last_pg
);
    localparam int HI_W = CMD_AW - MEM_AW;

    // Classify the address and derive its page limits.
    always_comb begin
        loc        = addr[MEM_AW-1:0];
        in_range   = (addr[CMD_AW-1:MEM_AW] == {HI_W{1'b0}});
        is_alias   = (addr == {CMD_AW{1'b1}});
        is_optp    = in_range && (loc == {MEM_AW{1'b1}});
        pg_first   = {addr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
        pg_last    = {addr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b1}}};
        in_last_pg = &addr[MEM_AW-1:PAGE_AW];
    end
endmodule

// File: rtl/fsa_option_guard.sv
// Option byte shadow and security state.
// Holds a copy of the option byte, whether it is programmed, and derives
// the security flag. Loaded at boot; updated by writes and erases.
// Assumes: only one of boot_load, wr_en, clr_en is high in a cycle.
module fsa_option_guard #(
    parameter int SEC_BIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_load,
    input  logic [7:0] boot_value,
    input  logic       wr_en,
    input  logic [7:0] wr_value,
    input  logic       clr_en,
    output logic [7:0] opt_val,
    output logic       blank,
    output logic       secure
);
    import flashsec_pkg::*;

    // Track the option byte value and its programmed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_val <= ERASED_BYTE;
            blank   <= 1'b1;
        end else if (boot_load) begin
            opt_val <= boot_value;
            blank   <= (boot_value == ERASED_BYTE);
        end else if (wr_en) begin
            opt_val <= wr_value;
            blank   <= 1'b0;
        end else if (clr_en) begin
            opt_val <= ERASED_BYTE;
            blank   <= 1'b1;
        end
    end

    // Security counts only for a programmed option byte.
    assign secure = !blank && opt_val[SEC_BIT];

    // Check: a write to the option byte leaves it programmed.
    a_r9_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !boot_load) |=> !blank);

    // Check: an erase clears the shadow to the unprogrammed state.
    a_r7_clear_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en && !boot_load) |=> (blank && !secure));
endmodule

// File: rtl/fsa_erase_walker.sv
// Address walker for erase operations.
// Loads a first and last location, then steps one location per cycle.
// Assumes: first <= last, and step is held while the walk runs.
module fsa_erase_walker #(
    parameter int MEM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] first,
    input  logic [MEM_AW-1:0] last_loc,
    input  logic              step,
    output logic [MEM_AW-1:0] ptr,
    output logic              at_end
);
    logic [MEM_AW-1:0] lim;

    // Load the range on start, advance the pointer on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            lim <= '0;
        end else if (start) begin
            ptr <= first;
            lim <= last_loc;
        end else if (step && !at_end) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Flag the final location of the walk.
    assign at_end = (ptr == lim);

    // Check: the pointer never moves past the limit during a walk.
    a_r8_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && at_end) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/flash_sec_ctrl.sv
// Secured flash programming access controller (top).
// Sequences read, write, page erase and mass erase commands onto a
// byte-wide memory port and gates them by the option byte security bit.
// Assumes: memory reads return data one cycle after mem_re; writes take
// one cycle; the option byte lives at the top memory location.
module flash_sec_ctrl #(
    parameter int MEM_AW     = 15,
    parameter int CMD_AW     = 16,
    parameter int PAGE_BYTES = 128,
    parameter int SEC_BIT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [7:0]        rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    import flashsec_pkg::*;

    localparam int                PAGE_AW = $clog2(PAGE_BYTES);
    localparam logic [MEM_AW-1:0] OPT_LOC = {MEM_AW{1'b1}};

    st_e               st;
    op_e               op_q;
    logic [CMD_AW-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic              err_q;
    logic              clr_q;
    logic [7:0]        rdata_q;

    logic              in_range, is_alias, is_optp, in_last_pg;
    logic [MEM_AW-1:0] loc, pg_first, pg_last;
    logic [7:0]        opt_val;
    logic              blank, secure;
    logic [MEM_AW-1:0] walk_ptr;
    logic              walk_end;

    logic              in_check, wr_ok, er_ok, rd_mem, erase_go, is_erase_op;
    logic [MEM_AW-1:0] walk_first, walk_last;

    fsa_addr_decode #(.CMD_AW(CMD_AW), .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_dec (
        .addr       (addr_q),
        .in_range   (in_range),
        .is_alias   (is_alias),
        .is_optp    (is_optp),
        .loc        (loc),
        .pg_first   (pg_first),
        .pg_last    (pg_last),
        .in_last_pg (in_last_pg)
    );

    fsa_option_guard #(.SEC_BIT(SEC_BIT)) u_opt (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_load  (st == ST_BOOTWAIT),
        .boot_value (mem_rdata),
        .wr_en      (in_check && op_q == OP_WRITE && wr_ok && is_optp),
        .wr_value   (wdata_q),
        .clr_en     (st == ST_ERASE && walk_end && clr_q),
        .opt_val    (opt_val),
        .blank      (blank),
        .secure     (secure)
    );

    fsa_erase_walker #(.MEM_AW(MEM_AW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (erase_go),
        .first    (walk_first),
        .last_loc (walk_last),
        .step     (st == ST_ERASE),
        .ptr      (walk_ptr),
        .at_end   (walk_end)
    );

    // Decide whether the held command may proceed.
    always_comb begin
        in_check    = (st == ST_CHECK);
        is_erase_op = (op_q == OP_PERASE) || (op_q == OP_MERASE);
        wr_ok       = in_range && !secure && (!is_optp || blank);
        er_ok       = (op_q == OP_MERASE) || (in_range && !secure);
        rd_mem      = in_range && !secure && !is_optp;
        erase_go    = in_check && is_erase_op && er_ok;
        walk_first  = (op_q == OP_MERASE) ? '0 : pg_first;
        walk_last   = (op_q == OP_MERASE) ? OPT_LOC : pg_last;
    end

    // Drive the memory port from the current state.
    always_comb begin
        mem_re    = (st == ST_BOOT) || (in_check && op_q == OP_READ && !is_alias && rd_mem);
        mem_we    = (st == ST_ERASE) || (in_check && op_q == OP_WRITE && wr_ok);
        mem_wdata = (st == ST_ERASE) ? ERASED_BYTE : wdata_q;
        if (st == ST_BOOT)       mem_addr = OPT_LOC;
        else if (st == ST_ERASE) mem_addr = walk_ptr;
        else                     mem_addr = loc;
    end

    // Command sequencer: boot load, accept, check, execute, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_BOOT;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            err_q   <= 1'b0;
            clr_q   <= 1'b0;
            rdata_q <= ERASED_BYTE;
        end else begin
            case (st)
                ST_BOOT:     st <= ST_BOOTWAIT;
                ST_BOOTWAIT: st <= ST_IDLE;
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= op_e'(cmd_op);
                        addr_q  <= cmd_addr;
                        wdata_q <= cmd_wdata;
                        err_q   <= 1'b0;
                        st      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    case (op_q)
                        OP_READ: begin
                            if (is_alias || is_optp) begin
                                rdata_q <= opt_val;
                                st      <= ST_DONE;
                            end else if (!rd_mem) begin
                                rdata_q <= ERASED_BYTE;
                                st      <= ST_DONE;
                            end else begin
                                st <= ST_RDWAIT;
                            end
                        end
                        OP_WRITE: begin
                            err_q <= !wr_ok;
                            st    <= ST_DONE;
                        end
                        default: begin
                            clr_q <= (op_q == OP_MERASE) || in_last_pg;
                            err_q <= !er_ok;
                            st    <= er_ok ? ST_ERASE : ST_DONE;
                        end
                    endcase
                end
                ST_RDWAIT: begin
                    rdata_q <= mem_rdata;
                    st      <= ST_DONE;
                end
                ST_ERASE: begin
                    if (walk_end) st <= ST_DONE;
                end
                ST_DONE:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Handshake and result outputs.
    assign busy  = (st != ST_IDLE);
    assign done  = (st == ST_DONE);
    assign err   = done && err_q;
    assign rdata = rdata_q;

    // Assertions on the handshake and memory gating.
    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    a_r6_no_secure_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == ST_CHECK) |-> !secure);
    a_r9_option_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == ST_CHECK && mem_addr == OPT_LOC) |-> blank);
    a_r8_erase_value: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == ST_ERASE) |-> (mem_wdata == ERASED_BYTE));
    a_r12_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    a_r1_boot_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BOOT || st == ST_BOOTWAIT) |-> (busy && !done));
endmodule

// File: tb/tb_flash_sec_ctrl.sv
module tb_flash_sec_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [7:0]  cmd_wdata;
    logic        busy, done, err;
    logic [7:0]  rdata;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory array behind the controller, sparse, erased value 0xFF.
    logic [7:0] fmem [int unsigned];
    always @(posedge clk) begin
        if (mem_we) fmem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= fmem.exists(int'(mem_addr)) ? fmem[int'(mem_addr)] : 8'hFF;
    end

    // Reference model state.
    logic [7:0] ref_mem [int unsigned];
    logic [7:0] ref_opt = 8'hFF;
    bit         ref_blank = 1;

    function automatic logic [7:0] ref_rd(input int unsigned a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
    endfunction

    function automatic void predict(input logic [1:0] op, input logic [15:0] a,
                                    input logic [7:0] wd, output bit e, output logic [7:0] d);
        bit inr  = (a < 16'h8000);
        bit alia = (a == 16'hFFFF);
        bit optp = (a == 16'h7FFF);
        bit sec  = !ref_blank && ref_opt[3];
        int unsigned base;
        e = 0; d = 8'hFF;
        case (op)
            2'b00: begin
                if (alia || optp)     d = ref_opt;
                else if (!inr || sec) d = 8'hFF;
                else                  d = ref_rd(int'(a));
            end
            2'b01: begin
                if (!inr || sec || (optp && !ref_blank)) e = 1;
                else begin
                    ref_mem[int'(a)] = wd;
                    if (optp) begin ref_opt = wd; ref_blank = 0; end
                end
            end
            2'b10: begin
                if (!inr || sec) e = 1;
                else begin
                    base = int'(a) & ~32'd127;
                    for (int i = 0; i < 128; i++) ref_mem[base + i] = 8'hFF;
                    if (base == 32'h7F80) begin ref_opt = 8'hFF; ref_blank = 1; end
                end
            end
            default: begin
                ref_mem.delete();
                ref_opt = 8'hFF; ref_blank = 1;
            end
        endcase
    endfunction

    typedef struct {
        string      tag;
        bit         is_rd;
        bit         e;
        logic [7:0] d;
    } item_t;
    item_t sbq [$];

    // Monitor: pops one expected item per done pulse and compares.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            item_t it;
            n_chk++;
            if (sbq.size() == 0) begin
                n_err++;
                $display("FAIL R2 unexpected done: actual done=1 expected no pending command");
            end else begin
                it = sbq.pop_front();
                if (err !== it.e) begin
                    n_err++;
                    $display("FAIL %s err: actual %b expected %b", it.tag, err, it.e);
                end
                if (it.is_rd) begin
                    n_chk++;
                    if (rdata !== it.d) begin
                        n_err++;
                        $display("FAIL %s rdata: actual %02h expected %02h", it.tag, rdata, it.d);
                    end
                end
            end
        end
    end

    // Driver: predicts, queues the expectation and issues one command.
    task automatic cmd(input logic [1:0] op, input logic [15:0] a,
                       input logic [7:0] wd, input string tag);
        bit e; logic [7:0] d; item_t it;
        predict(op, a, wd, e, d);
        it.tag = tag; it.is_rd = (op == 2'b00); it.e = e; it.d = d;
        sbq.push_back(it);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 0;
        n_chk++;
        if (busy !== 1'b1) begin
            n_err++;
            $display("FAIL R2 busy after accept: actual %b expected 1", busy);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_wdata = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (busy !== 1'b1 || done !== 1'b0 || err !== 1'b0) begin
            n_err++;
            $display("FAIL R1 reset outputs: actual busy=%b done=%b err=%b expected 1 0 0", busy, done, err);
        end
        rst_n = 1;
        ref_blank = (ref_rd(32'h7FFF) == 8'hFF);
        ref_opt   = ref_rd(32'h7FFF);
        @(negedge clk);
        n_chk++;
        if (busy !== 1'b1) begin
            n_err++;
            $display("FAIL R1 boot busy: actual %b expected 1", busy);
        end
        @(negedge clk); @(negedge clk);
        n_chk++;
        if (busy !== 1'b0) begin
            n_err++;
            $display("FAIL R1 idle after boot: actual %b expected 0", busy);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual run not complete expected completion");
        summary();
    end

    // Stimulus.
    initial begin
        do_reset();
        // R3 / R12: fresh memory and simple read/write
        cmd(2'b00, 16'h0100, 8'h00, "R3 fresh read");
        cmd(2'b01, 16'h0100, 8'h5A, "R12 write");
        cmd(2'b00, 16'h0100, 8'h00, "R3 readback");
        cmd(2'b01, 16'h0180, 8'hC3, "R3 write neighbour page");
        cmd(2'b00, 16'h7FFF, 8'h00, "R4 blank option phys");
        cmd(2'b00, 16'hFFFF, 8'h00, "R4 blank option alias");
        // R11: out of range
        cmd(2'b01, 16'h8000, 8'h12, "R11 write high");
        cmd(2'b00, 16'h9000, 8'h00, "R11 read high");
        cmd(2'b10, 16'h8100, 8'h00, "R11 page erase high");
        // R9 / R10: option once, unsecured value
        cmd(2'b01, 16'h7FFF, 8'h01, "R9 first option write");
        cmd(2'b00, 16'hFFFF, 8'h00, "R4 alias after write");
        cmd(2'b01, 16'h7FFF, 8'h08, "R9 second option write");
        cmd(2'b00, 16'h0100, 8'h00, "R10 bit3 clear readable");
        // R8: page erase of one page
        cmd(2'b01, 16'h0105, 8'h33, "R8 seed byte");
        cmd(2'b10, 16'h0142, 8'h00, "R8 page erase");
        cmd(2'b00, 16'h0105, 8'h00, "R8 erased byte");
        cmd(2'b00, 16'h0100, 8'h00, "R8 erased first");
        cmd(2'b00, 16'h0180, 8'h00, "R8 neighbour kept");
        // R9: last-page erase reopens the option byte, then secure it
        cmd(2'b10, 16'h7F80, 8'h00, "R9 last page erase");
        cmd(2'b00, 16'h7FFF, 8'h00, "R9 option erased");
        cmd(2'b01, 16'h7FFF, 8'h09, "R9 rewrite option");
        // R5 / R4 / R6 under security
        cmd(2'b00, 16'h0180, 8'h00, "R5 masked read");
        cmd(2'b00, 16'hFFFF, 8'h00, "R4 alias secured");
        cmd(2'b00, 16'h7FFF, 8'h00, "R4 phys secured");
        cmd(2'b01, 16'h0200, 8'h44, "R6 write refused");
        cmd(2'b10, 16'h0180, 8'h00, "R6 page erase refused");
        cmd(2'b10, 16'h7F80, 8'h00, "R6 last page erase refused");
        cmd(2'b01, 16'h7FFF, 8'h00, "R6 option write refused");
        // R10 / R1: reset reloads option from memory
        do_reset();
        cmd(2'b00, 16'h0180, 8'h00, "R10 secure after reboot");
        cmd(2'b00, 16'hFFFF, 8'h00, "R1 option reloaded");
        // R7: mass erase while secured
        cmd(2'b11, 16'h0000, 8'h00, "R7 mass erase");
        cmd(2'b00, 16'h0180, 8'h00, "R7 erased data");
        cmd(2'b00, 16'hFFFF, 8'h00, "R7 option blank");
        cmd(2'b01, 16'h0180, 8'h11, "R7 write after erase");
        cmd(2'b00, 16'h0180, 8'h00, "R7 security off readback");
        // Memory unchanged by refused write (R6): checked through readback
        cmd(2'b00, 16'h0200, 8'h00, "R6 refused write left 0xFF");
        repeat (4) @(negedge clk);
        n_chk++;
        if (sbq.size() != 0) begin
            n_err++;
            $display("FAIL R2 pending items: actual %0d expected 0", sbq.size());
        end
        summary();
    end
endmodule